// File: doc/BRIEF.md
# Timer with Shared Timer/Watchdog Prescaler

This block is an 8-bit event timer whose single programmable power-of-two divider can be given either to the timer or to a watchdog counter. A 6-bit option word sets four controls: the event source (instruction-cycle strobe or an external pin), the pin edge that counts, which counter gets the divider, and a 3-bit ratio code. The option word can only be loaded by its load strobe and has no read path. Software can load the timer at any time. The watchdog counts a free-running tick and raises a one-cycle time-out pulse when its counter overflows.

One ratio code means different things depending on where the divider is assigned. A timer assignment divides by 2^(code+1), so the range is 1:2 to 1:256. A watchdog assignment divides by 2^code, so the range is 1:1 to 1:128. Whichever counter does not hold the divider counts its own events undivided.

Top module: `tmr_wdt_div`

## Requirements
- R1: After a synchronous reset the timer reads 00h, no time-out is pulsed, and all six option bits are 1. The timer therefore counts falling pin edges undivided, and the divider serves the watchdog at code 7 (1:128).
- R2: Option bit positions are: bit 5 source (1 = pin), bit 4 edge (1 = falling), bit 3 assignment (1 = watchdog), bits 2:0 ratio code. The word is taken from `opt_wdata` only in a cycle with `opt_wr` high. Data on `opt_wdata` without the strobe has no effect.
- R3: With source 0, the timer counts clock cycles in which `cyc_stb` is high.
- R4: With source 1, the pin passes through a two-flop synchronizer. The timer counts rising edges when the edge bit is 0 and falling edges when it is 1. The count becomes visible after the third rising clock edge that follows the pin change.
- R5: With assignment 0, the timer advances once per 2^(code+1) source events.
- R6: With assignment 1, the timer advances on every source event, and the watchdog counter advances once per 2^code ticks.
- R7: The timer wraps from FFh to 00h.
- R8: A `tmr_wr` cycle loads `tmr_wdata`, taking priority over a count in the same cycle. When the assignment is 0 it also empties the divider.
- R9: The watchdog counter is WDT_W bits wide. `wdt_timeout` is high for exactly one cycle, in the cycle after the counted event that wraps the counter (the 2^WDT_W-th counted event after a clear).
- R10: `wdt_clr` empties the watchdog counter, empties the divider when the assignment is 1, and suppresses any time-out in the following cycle.
- R11: With assignment 0, the watchdog counter advances on every `wdt_tick`, whatever the ratio code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_stb | input | 1 | Instruction-cycle strobe, one clock per cycle |
| ext_pin | input | 1 | External count pin, asynchronous |
| opt_wr | input | 1 | Option load strobe |
| opt_wdata | input | 6 | Option word from the working register |
| tmr_wr | input | 1 | Timer load strobe |
| tmr_wdata | input | 8 | Timer load value |
| wdt_tick | input | 1 | Free-running watchdog tick, one clock wide |
| wdt_clr | input | 1 | Clear watchdog counter (and divider when assigned to it) |
| tmr_q | output | 8 | Timer value |
| wdt_timeout | output | 1 | One-cycle watchdog time-out pulse |

## Verification
The watchdog-pulse properties assume two things about the inputs. First, `wdt_tick` is a one-clock strobe. Second, the counter is at least two bits wide, so a wrap can never come on two consecutive counted events. The timer-step property assumes that nothing other than `tmr_wr` can move the timer by more than one per clock. The stimulus keeps to these limits. Every tick and strobe is high for one clock and is followed by a low clock. The pin is held for three clocks per level, so each edge clears the synchronizer before the next one arrives. The strobes and ticks stay low during option and timer loads, except in the one cycle that checks load priority.

// File: rtl/tmr_wdt_pkg.sv
package tmr_wdt_pkg;
  localparam int RATIO_W = 3;
  localparam int OPT_W   = RATIO_W + 3;

  // bit 5 source, bit 4 edge, bit 3 assignment, bits 2:0 ratio code
  typedef struct packed {
    logic               src_ext;
    logic               fall_edge;
    logic               pre_wdt;
    logic [RATIO_W-1:0] ratio;
  } opt_t;
endpackage

// File: rtl/tmr_opt_reg.sv
module tmr_opt_reg
  import tmr_wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [OPT_W-1:0] wdata,
  output opt_t             opt
);
  always_ff @(posedge clk) begin
    if (rst)       opt <= opt_t'('1);
    else if (load) opt <= opt_t'(wdata);
  end
endmodule

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic fall_sel,
  output logic edge_stb
);
  // STAGES synchronizer flops plus one history flop
  logic [STAGES:0] sh;
  logic            cur, prev;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], pin};
  end

  assign cur  = sh[STAGES-1];
  assign prev = sh[STAGES];

  always_comb begin
    if (fall_sel) edge_stb = prev & ~cur;
    else          edge_stb = cur & ~prev;
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int RATIO_W = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           evt_in,
  input  logic [RATIO_W:0] sel,
  output logic           evt_out
);
  localparam int PRE_W = 2 ** RATIO_W;
  localparam int NTAP  = PRE_W + 1;

  logic [PRE_W-1:0] cnt;
  logic [NTAP-1:0]  full;

  // full[k]: low k bits all ones, so the next event completes a 2^k group
  assign full[0] = 1'b1;
  for (genvar k = 1; k <= PRE_W; k++) begin : g_tap
    assign full[k] = &cnt[k-1:0];
  end

  assign evt_out = evt_in & full[sel];

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (evt_in) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tmr_wdt_cnt.sv
module tmr_wdt_cnt #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic timeout
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      timeout <= 1'b0;
    end else begin
      timeout <= 1'b0;
      if (clr) begin
        cnt <= '0;
      end else if (inc) begin
        cnt     <= cnt + 1'b1;
        timeout <= &cnt;
      end
    end
  end
endmodule

// File: rtl/tmr_wdt_div.sv
module tmr_wdt_div
  import tmr_wdt_pkg::*;
#(
  parameter int TMR_W       = 8,
  parameter int WDT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cyc_stb,
  input  logic                         ext_pin,
  input  logic                         opt_wr,
  input  logic [tmr_wdt_pkg::OPT_W-1:0] opt_wdata,
  input  logic                         tmr_wr,
  input  logic [TMR_W-1:0]             tmr_wdata,
  input  logic                         wdt_tick,
  input  logic                         wdt_clr,
  output logic [TMR_W-1:0]             tmr_q,
  output logic                         wdt_timeout
);
  localparam int SEL_W = RATIO_W + 1;

  opt_t             opt;
  logic             pin_evt, src_evt;
  logic             pre_in, pre_out, pre_clr;
  logic [SEL_W-1:0] pre_sel;
  logic             tmr_inc, wdt_inc;

  tmr_opt_reg u_opt (
    .clk   (clk),
    .rst   (rst),
    .load  (opt_wr),
    .wdata (opt_wdata),
    .opt   (opt)
  );

  tmr_pin_edge #(.STAGES(SYNC_STAGES)) u_pin (
    .clk      (clk),
    .rst      (rst),
    .pin      (ext_pin),
    .fall_sel (opt.fall_edge),
    .edge_stb (pin_evt)
  );

  assign src_evt = opt.src_ext ? pin_evt : cyc_stb;

  // divider routing: the ratio code is one step deeper on the timer side
  always_comb begin
    if (opt.pre_wdt) begin
      pre_in  = wdt_tick;
      pre_clr = wdt_clr;
      pre_sel = SEL_W'(opt.ratio);
      tmr_inc = src_evt;
    end else begin
      pre_in  = src_evt;
      pre_clr = tmr_wr;
      pre_sel = SEL_W'(opt.ratio) + 1'b1;
      tmr_inc = pre_out;
    end
  end

  tmr_prescaler #(.RATIO_W(RATIO_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .clr     (pre_clr),
    .evt_in  (pre_in),
    .sel     (pre_sel),
    .evt_out (pre_out)
  );

  assign wdt_inc = opt.pre_wdt ? pre_out : wdt_tick;

  tmr_wdt_cnt #(.CNT_W(WDT_W)) u_wdt (
    .clk     (clk),
    .rst     (rst),
    .clr     (wdt_clr),
    .inc     (wdt_inc),
    .timeout (wdt_timeout)
  );

  always_ff @(posedge clk) begin
    if (rst)          tmr_q <= '0;
    else if (tmr_wr)  tmr_q <= tmr_wdata;
    else if (tmr_inc) tmr_q <= tmr_q + 1'b1;
  end
endmodule

// File: rtl/tmr_wdt_div_chk.sv
module tmr_wdt_div_chk #(
  parameter int TMR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tmr_wr,
  input logic [TMR_W-1:0] tmr_wdata,
  input logic [TMR_W-1:0] tmr_q,
  input logic             wdt_tick,
  input logic             wdt_clr,
  input logic             wdt_timeout
);
  AST_TMR_STEP: assert property (@(posedge clk) disable iff (rst)
    !tmr_wr |=> (tmr_q == $past(tmr_q)) || (tmr_q == TMR_W'($past(tmr_q) + 1'b1))); // R7

  AST_TMR_LOAD: assert property (@(posedge clk) disable iff (rst)
    tmr_wr |=> tmr_q == $past(tmr_wdata)); // R8

  AST_TO_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wdt_timeout |=> !wdt_timeout); // R9

  AST_TO_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    wdt_timeout |-> $past(wdt_tick)); // R11

  AST_CLR_QUIET: assert property (@(posedge clk) disable iff (rst)
    wdt_clr |=> !wdt_timeout); // R10
endmodule

bind tmr_wdt_div tmr_wdt_div_chk #(.TMR_W(TMR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tmr_wr      (tmr_wr),
  .tmr_wdata   (tmr_wdata),
  .tmr_q       (tmr_q),
  .wdt_tick    (wdt_tick),
  .wdt_clr     (wdt_clr),
  .wdt_timeout (wdt_timeout)
);

// File: tb/sim_tmr_wdt_div.sv
module sim_tmr_wdt_div;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_stb = 1'b0;
  logic       ext_pin = 1'b0;
  logic       opt_wr = 1'b0;
  logic [5:0] opt_wdata = 6'h00;
  logic       tmr_wr = 1'b0;
  logic [7:0] tmr_wdata = 8'h00;
  logic       wdt_tick = 1'b0;
  logic       wdt_clr = 1'b0;
  logic [7:0] tmr_q;
  logic       wdt_timeout;

  int n_chk = 0;
  int n_fail = 0;
  int to_cnt = 0;

  always #10 clk = ~clk;

  tmr_wdt_div u0 (
    .clk(clk), .rst(rst), .cyc_stb(cyc_stb), .ext_pin(ext_pin),
    .opt_wr(opt_wr), .opt_wdata(opt_wdata), .tmr_wr(tmr_wr),
    .tmr_wdata(tmr_wdata), .wdt_tick(wdt_tick), .wdt_clr(wdt_clr),
    .tmr_q(tmr_q), .wdt_timeout(wdt_timeout)
  );

  always @(negedge clk) if (!rst && wdt_timeout) to_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input int n);
    repeat (n) begin cyc_stb = 1'b1; step(1); cyc_stb = 1'b0; step(1); end
  endtask

  task automatic ticks(input int n);
    repeat (n) begin wdt_tick = 1'b1; step(1); wdt_tick = 1'b0; step(1); end
  endtask

  task automatic set_opt(input logic [5:0] v);
    opt_wdata = v; opt_wr = 1'b1; step(1); opt_wr = 1'b0; opt_wdata = 6'h2A;
  endtask

  task automatic wr_tmr(input logic [7:0] v);
    tmr_wdata = v; tmr_wr = 1'b1; step(1); tmr_wr = 1'b0; tmr_wdata = 8'h5A;
  endtask

  task automatic clr_wdt();
    wdt_clr = 1'b1; step(1); wdt_clr = 1'b0; step(1);
  endtask

  task automatic pin_pulse(input int n);
    repeat (n) begin ext_pin = 1'b1; step(3); ext_pin = 1'b0; step(3); end
  endtask

  task automatic t_reset_defaults();
    int base;
    strobe(5);
    chk("R1 strobes ignored in pin mode", tmr_q, 0);
    ext_pin = 1'b1; step(3);
    chk("R1 rising edge not counted", tmr_q, 0);
    ext_pin = 1'b0; step(3);
    chk("R1 falling edge counted", tmr_q, 1);
    base = to_cnt;
    ticks(32767);
    chk("R1 no time-out before 256*128 ticks", to_cnt - base, 0);
    ticks(1);
    chk("R1 time-out at 256*128 ticks", to_cnt - base, 1);
  endtask

  task automatic t_opt_ignored();
    set_opt(6'h08);
    wr_tmr(8'h00);
    opt_wdata = 6'h00; step(2);
    strobe(4);
    chk("R2 option data without strobe ignored", tmr_q, 4);
  endtask

  task automatic t_timer_ratios();
    set_opt(6'h00); wr_tmr(8'h00); strobe(7);
    chk("R5 code0 1:2 (R3 internal)", tmr_q, 3);
    set_opt(6'h02); wr_tmr(8'h00); strobe(40);
    chk("R5 code2 1:8", tmr_q, 5);
    set_opt(6'h07); wr_tmr(8'h00); strobe(512);
    chk("R5 code7 1:256", tmr_q, 2);
    set_opt(6'h0F); wr_tmr(8'h10); strobe(9);
    chk("R6 timer undivided with divider on watchdog", tmr_q, 8'h19);
  endtask

  task automatic t_wrap();
    set_opt(6'h08); wr_tmr(8'hFE); strobe(3);
    chk("R7 wrap FF to 00", tmr_q, 1);
  endtask

  task automatic t_write();
    set_opt(6'h01); wr_tmr(8'h00); strobe(3);
    chk("R8 below ratio 4", tmr_q, 0);
    wr_tmr(8'h0A); strobe(3);
    chk("R8 write emptied divider", tmr_q, 8'h0A);
    strobe(1);
    chk("R8 fourth event after write", tmr_q, 8'h0B);
    set_opt(6'h08);
    cyc_stb = 1'b1; tmr_wdata = 8'h40; tmr_wr = 1'b1; step(1);
    cyc_stb = 1'b0; tmr_wr = 1'b0; step(1);
    chk("R8 write beats count", tmr_q, 8'h40);
  endtask

  task automatic t_pin_edges();
    set_opt(6'h28); wr_tmr(8'h00);
    ext_pin = 1'b1; step(2);
    chk("R4 rising not yet through sync", tmr_q, 0);
    step(1);
    chk("R4 rising counted third edge", tmr_q, 1);
    ext_pin = 1'b0; step(3);
    chk("R4 falling ignored in rising mode", tmr_q, 1);
    set_opt(6'h38); wr_tmr(8'h00);
    ext_pin = 1'b1; step(3);
    chk("R4 rising ignored in falling mode", tmr_q, 0);
    ext_pin = 1'b0; step(3);
    chk("R4 falling counted", tmr_q, 1);
    set_opt(6'h20); wr_tmr(8'h00); pin_pulse(6);
    chk("R4 pin edges through 1:2 divider", tmr_q, 3);
  endtask

  task automatic t_watchdog();
    int base;
    set_opt(6'h08); clr_wdt(); base = to_cnt;
    ticks(255);
    chk("R9 no time-out at 255", to_cnt - base, 0);
    ticks(1);
    chk("R9 single-cycle time-out at 256", to_cnt - base, 1);
    set_opt(6'h09); clr_wdt(); base = to_cnt;
    ticks(511);
    chk("R6 watchdog 1:2 no time-out at 511", to_cnt - base, 0);
    ticks(1);
    chk("R6 watchdog 1:2 time-out at 512", to_cnt - base, 1);
    clr_wdt(); ticks(1); clr_wdt(); base = to_cnt;
    ticks(511);
    chk("R10 clear emptied divider", to_cnt - base, 0);
    ticks(1);
    chk("R10 time-out after full span", to_cnt - base, 1);
    set_opt(6'h08); clr_wdt(); ticks(200); clr_wdt(); base = to_cnt;
    ticks(200);
    chk("R10 clear emptied counter", to_cnt - base, 0);
    ticks(56);
    chk("R10 time-out 256 after clear", to_cnt - base, 1);
    set_opt(6'h07); clr_wdt(); base = to_cnt;
    ticks(255);
    chk("R11 raw ticks no time-out at 255", to_cnt - base, 0);
    ticks(1);
    chk("R11 raw ticks time-out at 256", to_cnt - base, 1);
  endtask

  initial begin
    step(3);
    chk("R1 reset timer", tmr_q, 0);
    chk("R1 reset time-out", wdt_timeout, 0);
    rst = 1'b0;
    step(1);
    t_reset_defaults();
    t_opt_ignored();
    t_timer_ratios();
    t_wrap();
    t_write();
    t_pin_edges();
    t_watchdog();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog all R actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule